// File: doc/BRIEF.md
# Decode-Stage Stall and Flush Controller

This block is the decode-stage hazard control of a five-stage in-order pipeline that resolves branches and jumps during decode. It watches the instruction held in the fetch/decode register together with the destination and control fields of the instruction one stage ahead in execute. When the execute-stage instruction is a load whose destination is read by the decode-stage instruction, it freezes fetch for one cycle and sends a bubble forward. It also freezes a branch whose compare operand is still being computed by the instruction directly ahead of it, since the compare in decode cannot see that result yet.

When decode resolves a taken branch or a jump, the block redirects the PC and clears the instruction that was fetched behind it, so the redirect costs one cycle. A freeze always wins over a redirect in the same cycle; the branch stays in decode and is judged again once the bubble has gone by. The PC and the fetch/decode register are part of the block, so its effect on the fetch stream can be seen directly at the ports.

Top module: `hz_stall_ctrl`

## Requirements
- R1: Load-use stall: a stall is raised when `ex_mem_read_i` is 1 and the nonzero `ex_dst_i` equals either source field of the held instruction. The first source field is bits [25:21] and the second is bits [20:16].
- R2: During a stall, `pc_we_o` and `ifid_we_o` are 0. At the next clock edge, `pc_o` and `ifid_instr_o` keep their values.
- R3: `ctrl_zero_o` is 1 in exactly the cycles in which a stall is raised. This selects zeros for the control fields that go into the execute stage.
- R4: The load-use stall lasts one cycle. Once the execute stage holds the bubble (`ex_mem_read_i` = 0, `ex_reg_write_i` = 0), the stall drops and the PC advances.
- R5: Branch operand stall: a stall is raised when `id_branch_i` is 1, `ex_reg_write_i` is 1, and the nonzero `ex_dst_i` equals either source field. A writer with a matching destination causes no stall when the decode instruction is not a branch.
- R6: A jump, or a branch with `id_taken_i` = 1, raises `if_flush_o` when no stall is raised. At the next edge, `ifid_instr_o` becomes 0 and `pc_o` becomes `redirect_pc_i`.
- R7: When a stall and a redirect fall in the same cycle, `if_flush_o` is 0, and the PC and the fetch/decode register are held.
- R8: A destination of register 0 never causes a stall.
- R9: With no stall and no redirect, `pc_o` advances by 4 and `ifid_instr_o` loads `fetch_instr_i` at the next edge. Both write enables are 1 in that cycle.
- R10: While `rst_ni` is low, `pc_o` is 0 and `ifid_instr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_instr_i | input | 32 | Instruction word fetched at `pc_o` |
| redirect_pc_i | input | 32 | Target address of the jump or branch in decode |
| id_branch_i | input | 1 | Decode-stage instruction is a conditional branch |
| id_taken_i | input | 1 | Decode-stage branch compare result is taken |
| id_jump_i | input | 1 | Decode-stage instruction is an unconditional jump |
| ex_mem_read_i | input | 1 | Execute-stage instruction reads memory (load) |
| ex_reg_write_i | input | 1 | Execute-stage instruction writes a register |
| ex_dst_i | input | 5 | Destination register of the execute-stage instruction |
| pc_o | output | 32 | Current fetch address |
| ifid_instr_o | output | 32 | Instruction held in the fetch/decode register |
| pc_we_o | output | 1 | PC write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| ctrl_zero_o | output | 1 | Select zeros for the control fields entering execute |
| if_flush_o | output | 1 | Clear the fetched instruction into a no-op |

## Verification
A stall and a redirect can fall in the same cycle. The bench provokes this in two ways. In the first, a taken branch has a compare operand that the instruction in execute is still writing. In the second, a jump sits in decode behind a load whose destination matches one of the jump word's source fields. In both cases the check is that `if_flush_o` stays low and the bubble select is raised. At the following edge, the PC must equal its old value rather than the redirect target, and the held instruction must be unchanged rather than cleared.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_SEQ  = 2'd1,
    PC_JMP  = 2'd2
  } pc_sel_e;

  typedef enum logic [1:0] {
    IFID_HOLD  = 2'd0,
    IFID_LOAD  = 2'd1,
    IFID_CLEAR = 2'd2
  } ifid_sel_e;
endpackage

// File: rtl/hz_detect.sv
module hz_detect #(
  parameter int INSTR_W = 32,
  parameter int REG_AW  = 5,
  parameter int SRC_A_LSB = 21,
  parameter int SRC_B_LSB = 16
) (
  input  logic [INSTR_W-1:0] ifid_instr_i,
  input  logic               ex_mem_read_i,
  input  logic               ex_reg_write_i,
  input  logic [REG_AW-1:0]  ex_dst_i,
  input  logic               id_branch_i,
  output logic               load_use_o,
  output logic               branch_dep_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] src_hit;
  logic            dst_live;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int LSB = (g == 0) ? SRC_A_LSB : SRC_B_LSB;
    assign src_hit[g] = (ifid_instr_i[LSB +: REG_AW] == ex_dst_i);
  end

  // register 0 is hard-wired, never a real producer
  assign dst_live     = |ex_dst_i;
  assign load_use_o   = ex_mem_read_i & dst_live & (|src_hit);
  assign branch_dep_o = id_branch_i & ex_reg_write_i & dst_live & (|src_hit);
endmodule

// File: rtl/hz_pc_reg.sv
module hz_pc_reg
  import hz_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          STEP     = 4,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  pc_sel_e         sel_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    unique case (sel_i)
      PC_SEQ:  pc_d = pc_q + PC_W'(STEP);
      PC_JMP:  pc_d = target_i;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC[PC_W-1:0];
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/hz_ifid_reg.sv
module hz_ifid_reg
  import hz_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ifid_sel_e          sel_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [INSTR_W-1:0] instr_o
);
  logic [INSTR_W-1:0] instr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q <= '0;
    end else begin
      unique case (sel_i)
        IFID_LOAD:  instr_q <= instr_i;
        IFID_CLEAR: instr_q <= '0;  // all-zero word decodes as no-op
        default:    instr_q <= instr_q;
      endcase
    end
  end

  assign instr_o = instr_q;
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int          INSTR_W   = 32,
  parameter int          PC_W      = 32,
  parameter int          REG_AW    = 5,
  parameter int          SRC_A_LSB = 21,
  parameter int          SRC_B_LSB = 16,
  parameter logic [31:0] RESET_PC  = 32'h0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] fetch_instr_i,
  input  logic [PC_W-1:0]    redirect_pc_i,
  input  logic               id_branch_i,
  input  logic               id_taken_i,
  input  logic               id_jump_i,
  input  logic               ex_mem_read_i,
  input  logic               ex_reg_write_i,
  input  logic [REG_AW-1:0]  ex_dst_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] ifid_instr_o,
  output logic               pc_we_o,
  output logic               ifid_we_o,
  output logic               ctrl_zero_o,
  output logic               if_flush_o
);
  localparam int STEP = INSTR_W / 8;

  logic      load_use, branch_dep, stall, redirect;
  pc_sel_e   pc_sel;
  ifid_sel_e ifid_sel;

  hz_detect #(
    .INSTR_W  (INSTR_W),
    .REG_AW   (REG_AW),
    .SRC_A_LSB(SRC_A_LSB),
    .SRC_B_LSB(SRC_B_LSB)
  ) u_detect (
    .ifid_instr_i  (ifid_instr_o),
    .ex_mem_read_i (ex_mem_read_i),
    .ex_reg_write_i(ex_reg_write_i),
    .ex_dst_i      (ex_dst_i),
    .id_branch_i   (id_branch_i),
    .load_use_o    (load_use),
    .branch_dep_o  (branch_dep)
  );

  assign stall    = load_use | branch_dep;
  assign redirect = id_jump_i | (id_branch_i & id_taken_i);

  // stall beats redirect: branch is re-judged after the bubble
  always_comb begin
    if (stall) begin
      pc_sel   = PC_HOLD;
      ifid_sel = IFID_HOLD;
    end else if (redirect) begin
      pc_sel   = PC_JMP;
      ifid_sel = IFID_CLEAR;
    end else begin
      pc_sel   = PC_SEQ;
      ifid_sel = IFID_LOAD;
    end
  end

  assign pc_we_o     = ~stall;
  assign ifid_we_o   = ~stall;
  assign ctrl_zero_o = stall;
  assign if_flush_o  = (ifid_sel == IFID_CLEAR);

  hz_pc_reg #(
    .PC_W    (PC_W),
    .STEP    (STEP),
    .RESET_PC(RESET_PC)
  ) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (pc_sel),
    .target_i(redirect_pc_i),
    .pc_o    (pc_o)
  );

  hz_ifid_reg #(
    .INSTR_W(INSTR_W)
  ) u_ifid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (ifid_sel),
    .instr_i(fetch_instr_i),
    .instr_o(ifid_instr_o)
  );

  p_stall_holds_pc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_we_o |=> pc_o == $past(pc_o));
  p_stall_holds_ifid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ifid_we_o |=> $stable(ifid_instr_o));
  p_bubble_with_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_zero_o |-> !ifid_we_o && !pc_we_o);
  p_flush_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_flush_o |=> ifid_instr_o == '0);
  p_flush_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_flush_o |=> pc_o == $past(redirect_pc_i));
  p_stall_over_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_jump_i && !pc_we_o) |-> !if_flush_o);
  p_r0_no_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_dst_i == '0) |-> pc_we_o);
  p_seq_advance_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o && !if_flush_o) |=> pc_o == $past(pc_o) + PC_W'(STEP));
endmodule

// File: tb/hz_stall_ctrl_tb.sv
`timescale 1ns/1ps
module hz_stall_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_instr = '0;
  logic [31:0] redirect_pc = '0;
  logic        br = 1'b0, tk = 1'b0, jp = 1'b0, mr = 1'b0, rw = 1'b0;
  logic [4:0]  dst = '0;
  logic [31:0] pc, ifid;
  logic        pc_we, ifid_we, czero, flush;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hz_stall_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_instr_i(fetch_instr),
    .redirect_pc_i(redirect_pc), .id_branch_i(br), .id_taken_i(tk),
    .id_jump_i(jp), .ex_mem_read_i(mr), .ex_reg_write_i(rw), .ex_dst_i(dst),
    .pc_o(pc), .ifid_instr_o(ifid), .pc_we_o(pc_we), .ifid_we_o(ifid_we),
    .ctrl_zero_o(czero), .if_flush_o(flush)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] a, input logic [4:0] b);
    return {6'h23, a, b, 16'h0040};
  endfunction

  task automatic quiet();
    br = 0; tk = 0; jp = 0; mr = 0; rw = 0; dst = '0;
  endtask

  // {src_a, src_b, mr, rw, dst, br, tk, jp, exp_stall, exp_flush}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {5'd3, 5'd4, 1'b1, 1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 first source
    {5'd3, 5'd4, 1'b1, 1'b1, 5'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 second source
    {5'd3, 5'd4, 1'b1, 1'b1, 5'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 no match
    {5'd0, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 load to r0
    {5'd3, 5'd4, 1'b0, 1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 non-branch
    {5'd3, 5'd4, 1'b0, 1'b1, 5'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 branch dep
    {5'd3, 5'd4, 1'b0, 1'b1, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 taken+dep
    {5'd3, 5'd4, 1'b0, 1'b1, 5'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 taken
    {5'd3, 5'd4, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 jump
    {5'd3, 5'd4, 1'b0, 1'b1, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 not taken
    {5'd0, 5'd0, 1'b0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 branch r0
    {5'd3, 5'd4, 1'b1, 1'b1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}  // R7 load+jump
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pc0, ifid0, fi;
    logic        es, ef;
    quiet();
    #9;
    check("R10 reset pc", pc, 32'h0);
    check("R10 reset ifid", ifid, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R9 plain sequential fetch
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      pc0 = pc;
      fetch_instr = 32'h0bad_0000 + k;
      @(posedge clk); #1;
      check("R9 pc step", pc, pc0 + 4);
      check("R9 ifid load", ifid, 32'h0bad_0000 + k);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      quiet();
      fetch_instr = mk(VEC[i][21:17], VEC[i][16:12]);
      @(negedge clk);
      mr = VEC[i][11]; rw = VEC[i][10]; dst = VEC[i][9:5];
      br = VEC[i][4]; tk = VEC[i][3]; jp = VEC[i][2];
      es = VEC[i][1]; ef = VEC[i][0];
      fi = 32'h1234_0000 + i;
      fetch_instr = fi;
      redirect_pc = 32'h0000_8000 + 32'(i) * 16;
      #1;
      pc0 = pc; ifid0 = ifid;
      check($sformatf("R1/R5 pc_we vec%0d", i), {31'd0, pc_we}, {31'd0, ~es});
      check($sformatf("R2 ifid_we vec%0d", i), {31'd0, ifid_we}, {31'd0, ~es});
      check($sformatf("R3 ctrl_zero vec%0d", i), {31'd0, czero}, {31'd0, es});
      check($sformatf("R6/R7 flush vec%0d", i), {31'd0, flush}, {31'd0, ef});
      @(posedge clk); #1;
      if (es) begin
        check($sformatf("R2 pc held vec%0d", i), pc, pc0);
        check($sformatf("R2 ifid held vec%0d", i), ifid, ifid0);
      end else if (ef) begin
        check($sformatf("R6 pc target vec%0d", i), pc, 32'h0000_8000 + 32'(i) * 16);
        check($sformatf("R6 ifid zero vec%0d", i), ifid, 32'h0);
      end else begin
        check($sformatf("R9 pc step vec%0d", i), pc, pc0 + 4);
        check($sformatf("R9 ifid load vec%0d", i), ifid, fi);
      end
    end

    // R4: one-cycle load-use stall, then bubble in execute lets fetch move on
    @(negedge clk);
    quiet();
    fetch_instr = mk(5'd6, 5'd2);
    @(negedge clk);
    mr = 1; rw = 1; dst = 5'd6;
    fetch_instr = 32'h5555_0000;
    #1;
    pc0 = pc;
    check("R4 stall raised", {31'd0, pc_we}, 32'd0);
    @(negedge clk);
    mr = 0; rw = 0; dst = 5'd0;
    #1;
    check("R4 stall gone", {31'd0, pc_we}, 32'd1);
    check("R4 no bubble", {31'd0, czero}, 32'd0);
    @(posedge clk); #1;
    check("R4 pc advances", pc, pc0 + 4);
    check("R4 ifid loads", ifid, 32'h5555_0000);

    // R7: branch stalled then re-judged taken after the bubble
    @(negedge clk);
    quiet();
    fetch_instr = mk(5'd8, 5'd9);
    @(negedge clk);
    br = 1; tk = 1; rw = 1; dst = 5'd9;
    redirect_pc = 32'h0000_c000;
    #1;
    check("R7 flush blocked", {31'd0, flush}, 32'd0);
    @(negedge clk);
    rw = 0; dst = 5'd0;
    #1;
    check("R7 flush after bubble", {31'd0, flush}, 32'd1);
    @(posedge clk); #1;
    check("R7 pc target", pc, 32'h0000_c000);
    check("R7 ifid zero", ifid, 32'h0);

    // R10 asynchronous reset mid-run
    @(negedge clk);
    quiet();
    rst_n = 1'b0;
    #1;
    check("R10 async pc", pc, 32'h0);
    check("R10 async ifid", ifid, 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule